// File: doc/BRIEF.md
# Windowed Line-Burst Bus Initiator

This block sits on the initiator side of a processor-to-peripheral bus bridge. It accepts one processor request at a time and turns it into master cycles on a shared, multiplexed address/data bus. Bus signals are shown active-high here; the pads invert them. A base/mask pair marks one prefetchable address window.

A load whose address falls inside the window becomes an eight-word line fill. The fill always starts at word 0 of the line, whichever word was asked for. Any other load, and every ordinary store, becomes a single-beat cycle. A dirty-line cast-out becomes an eight-word burst write of the whole line. Line traffic is not snooped and carries no coherency state. The request is answered with a one-cycle response once the bus cycle has finished. For a read, that response carries the requested word and the captured line.

Each cycle runs through the same phases in order. The block requests the bus until it is granted, then drives one address phase. A read then spends one turnaround clock. The data phases follow, and one closing clock ends the cycle. If the target signals retry on the first data phase, the whole transfer goes back to arbitration and restarts from word 0.

Top module: `cwb_initiator`

## Requirements
- R1: An address hits the window when (address AND mask) equals base. Window membership decides only whether a load is a burst or a single beat.
- R2: A load that hits the window issues command 4'hE with the line-aligned address (low five bits zero), so word 0 goes first. It then takes exactly 8 data phases.
- R3: A load that misses the window issues command 4'h6 with the unmodified request address and takes exactly 1 data phase.
- R4: A store (req_op 2'd1) always issues command 4'h7 with a single data phase carrying req_wdata, even when its address hits the window.
- R5: A cast-out (req_op 2'd2) issues command 4'h7 at the line-aligned address. It then writes 8 words in index order, where word i is req_line[32*i +: 32]. Load is req_op 2'd0.
- R6: Phase order is fixed: bus request until grant, then one address phase (frame high, AD driven, irdy low). A read has one turnaround clock with irdy high. The data phases follow, then one closing clock in which resp_valid pulses. Without wait states or retry, resp_valid comes 2+beats clocks after the address phase for a read and 1+beats for a write.
- R7: frame_o stays high through every data phase but the last, and falls with irdy_o high for the final data phase.
- R8: Once irdy_o is high it stays high until a data phase completes (trdy_i), so target wait states stretch the transfer without loss.
- R9: stop_i without trdy_i in the first data phase abandons the cycle. The block requests the bus again, drives a new address phase at the same start address, and transfers all words from word 0.
- R10: resp_valid is a single-cycle pulse issued only after every data phase has completed. For a read, resp_data is the requested word (word 0 of the capture for a single beat) and resp_line holds the full captured line.
- R11: After reset, and whenever req_ready is high, the block drives no bus request, frame or irdy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_win_base | input | AW | Window base address |
| cfg_win_mask | input | AW | Window compare mask |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_op | input | 2 | 0 load, 1 store, 2 cast-out |
| req_addr | input | AW | Request byte address |
| req_wdata | input | DW | Store data |
| req_line | input | WORDS*DW | Cast-out line, word i at bits DW*i |
| resp_valid | output | 1 | Request finished (one cycle) |
| resp_data | output | DW | Requested read word |
| resp_line | output | WORDS*DW | Captured read line |
| bus_req_o | output | 1 | Bus request to the arbiter |
| bus_gnt_i | input | 1 | Bus grant from the arbiter |
| frame_o | output | 1 | Cycle framing, high until the last data phase |
| irdy_o | output | 1 | Initiator ready |
| ad_o | output | AW | Address / write data out |
| ad_oe_o | output | 1 | AD output enable |
| cmd_o | output | 4 | Command during the address phase |
| ad_i | input | DW | Read data from the target |
| trdy_i | input | 1 | Target ready, completes a data phase |
| stop_i | input | 1 | Target stop / retry |

## Verification
The assertions assume that the target asserts trdy_i and stop_i only while irdy_o is high, never during the read turnaround clock. They also assume stop_i without trdy_i occurs only in the first data phase, and that the grant arrives only while a request is pending. The bench's target model follows these rules. It raises its ready or stop only in cycles after the address phase (two for reads, one for writes) and only while irdy_o is high, and it inserts its single retry only on data phase 0. Its grant simply follows bus_req_o.

// File: rtl/cwb_pkg.sv
package cwb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ARB, ST_ADDR, ST_TURN, ST_DATA, ST_CLOSE
  } cwb_state_e;

  typedef enum logic [1:0] {
    OP_LOAD = 2'd0, OP_STORE = 2'd1, OP_CASTOUT = 2'd2, OP_RSVD = 2'd3
  } cwb_op_e;

  localparam logic [3:0] CMD_MEM_RD   = 4'h6;
  localparam logic [3:0] CMD_MEM_WR   = 4'h7;
  localparam logic [3:0] CMD_LINE_RD  = 4'hE;
endpackage

// File: rtl/cwb_window_decode.sv
module cwb_window_decode
  import cwb_pkg::*;
#(
  parameter int AW   = 32,
  parameter int OFFW = 5
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] mask,
  input  logic [1:0]    op,
  output logic          hit,
  output logic          burst,
  output logic          is_read,
  output logic [AW-1:0] start_addr
);
  function automatic logic window_hit(input logic [AW-1:0] a,
                                      input logic [AW-1:0] b,
                                      input logic [AW-1:0] m);
    return (a & m) == b;
  endfunction

  function automatic logic [AW-1:0] line_align(input logic [AW-1:0] a);
    return {a[AW-1:OFFW], {OFFW{1'b0}}};
  endfunction

  always_comb begin
    hit        = window_hit(addr, base, mask);
    is_read    = (op == OP_LOAD);
    burst      = (op == OP_CASTOUT) || (is_read && hit);
    start_addr = burst ? line_align(addr) : addr;
  end
endmodule

// File: rtl/cwb_master_fsm.sv
module cwb_master_fsm
  import cwb_pkg::*;
#(
  parameter int WORDS = 8,
  parameter int IDXW  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            rd,
  input  logic            burst,
  input  logic            gnt,
  input  logic            trdy,
  input  logic            stop,
  output logic [IDXW-1:0] beat,
  output logic            idle,
  output logic            bus_req,
  output logic            frame,
  output logic            irdy,
  output logic            addr_phase,
  output logic            data_phase,
  output logic            beat_done,
  output logic            retry_hit,
  output logic            close
);
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(WORDS - 1);

  cwb_state_e st_q, st_d;
  logic       last_beat;

  assign last_beat  = beat == (burst ? LAST_IDX : '0);
  assign data_phase = (st_q == ST_DATA);
  assign beat_done  = data_phase && trdy;
  assign retry_hit  = data_phase && stop && !trdy && (beat == '0);
  assign idle       = (st_q == ST_IDLE);
  assign bus_req    = (st_q == ST_ARB);
  assign addr_phase = (st_q == ST_ADDR);
  assign irdy       = (st_q == ST_TURN) || data_phase;
  assign frame      = addr_phase || (irdy && !last_beat);
  assign close      = (st_q == ST_CLOSE);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start) st_d = ST_ARB;
      ST_ARB:   if (gnt) st_d = ST_ADDR;
      ST_ADDR:  st_d = rd ? ST_TURN : ST_DATA;
      ST_TURN:  st_d = ST_DATA;
      ST_DATA: begin
        if (retry_hit)                  st_d = ST_ARB;
        else if (beat_done && last_beat) st_d = ST_CLOSE;
      end
      ST_CLOSE: st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      beat <= '0;
    end else begin
      st_q <= st_d;
      if (addr_phase)                   beat <= '0;
      else if (beat_done && !last_beat) beat <= beat + 1'b1;
    end
  end
endmodule

// File: rtl/cwb_line_buf.sv
module cwb_line_buf #(
  parameter int DW    = 32,
  parameter int WORDS = 8,
  parameter int IDXW  = 3
) (
  input  logic               clk,
  input  logic               we,
  input  logic [IDXW-1:0]    idx,
  input  logic [DW-1:0]      din,
  output logic [WORDS*DW-1:0] line
);
  logic [DW-1:0] slot [WORDS];

  always_ff @(posedge clk) begin
    if (we) slot[idx] <= din;
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_flat
    assign line[g*DW +: DW] = slot[g];
  end
endmodule

// File: rtl/cwb_initiator.sv
module cwb_initiator
  import cwb_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int WORDS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AW-1:0]       cfg_win_base,
  input  logic [AW-1:0]       cfg_win_mask,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [1:0]          req_op,
  input  logic [AW-1:0]       req_addr,
  input  logic [DW-1:0]       req_wdata,
  input  logic [WORDS*DW-1:0] req_line,
  output logic                resp_valid,
  output logic [DW-1:0]       resp_data,
  output logic [WORDS*DW-1:0] resp_line,
  output logic                bus_req_o,
  input  logic                bus_gnt_i,
  output logic                frame_o,
  output logic                irdy_o,
  output logic [AW-1:0]       ad_o,
  output logic                ad_oe_o,
  output logic [3:0]          cmd_o,
  input  logic [DW-1:0]       ad_i,
  input  logic                trdy_i,
  input  logic                stop_i
);
  localparam int IDXW = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int OFFW = IDXW + $clog2(DW / 8);

  logic            dec_hit, dec_burst, dec_read;
  logic [AW-1:0]   dec_start;
  logic            accept;
  logic            cur_read, cur_burst;
  logic [AW-1:0]   cur_addr;
  logic [IDXW-1:0] cur_widx;
  logic [DW-1:0]   cur_wdata;
  logic [WORDS*DW-1:0] cur_line;
  logic [IDXW-1:0] beat;
  logic            addr_phase, data_phase, beat_done, retry_hit, close;
  logic [WORDS*DW-1:0] rline;

  cwb_window_decode #(.AW(AW), .OFFW(OFFW)) u_dec (
    .addr(req_addr), .base(cfg_win_base), .mask(cfg_win_mask), .op(req_op),
    .hit(dec_hit), .burst(dec_burst), .is_read(dec_read), .start_addr(dec_start)
  );

  assign accept = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_read  <= 1'b0;
      cur_burst <= 1'b0;
      cur_addr  <= '0;
      cur_widx  <= '0;
      cur_wdata <= '0;
      cur_line  <= '0;
    end else if (accept) begin
      cur_read  <= dec_read;
      cur_burst <= dec_burst;
      cur_addr  <= dec_start;
      cur_widx  <= (dec_read && dec_hit) ? req_addr[OFFW-1 -: IDXW] : '0;
      cur_wdata <= req_wdata;
      cur_line  <= req_line;
    end
  end

  cwb_master_fsm #(.WORDS(WORDS), .IDXW(IDXW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(accept), .rd(cur_read), .burst(cur_burst),
    .gnt(bus_gnt_i), .trdy(trdy_i), .stop(stop_i), .beat(beat), .idle(req_ready),
    .bus_req(bus_req_o), .frame(frame_o), .irdy(irdy_o), .addr_phase(addr_phase),
    .data_phase(data_phase), .beat_done(beat_done), .retry_hit(retry_hit),
    .close(close)
  );

  cwb_line_buf #(.DW(DW), .WORDS(WORDS), .IDXW(IDXW)) u_buf (
    .clk(clk), .we(beat_done && cur_read), .idx(beat), .din(ad_i), .line(rline)
  );

  always_comb begin
    ad_oe_o = addr_phase || (data_phase && !cur_read);
    cmd_o   = '0;
    ad_o    = '0;
    if (addr_phase) begin
      ad_o  = cur_addr;
      cmd_o = !cur_read ? CMD_MEM_WR : (cur_burst ? CMD_LINE_RD : CMD_MEM_RD);
    end else if (data_phase && !cur_read) begin
      ad_o = cur_burst ? AW'(cur_line[beat*DW +: DW]) : AW'(cur_wdata);
    end
  end

  assign resp_valid = close;
  assign resp_line  = rline;
  assign resp_data  = rline[cur_widx*DW +: DW];
endmodule

// File: rtl/cwb_initiator_chk.sv
module cwb_initiator_chk #(
  parameter int WORDS = 8
) (
  input logic clk,
  input logic rst_n,
  input logic frame_o,
  input logic irdy_o,
  input logic bus_req_o,
  input logic trdy_i,
  input logic stop_i,
  input logic resp_valid,
  input logic req_ready,
  input logic beat_done,
  input logic retry_hit,
  input logic addr_phase,
  input logic cur_burst
);
  localparam int CW = $clog2(WORDS + 1) + 1;
  logic [CW-1:0] seen;
  logic [CW-1:0] want;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          seen <= '0;
    else if (addr_phase) seen <= '0;
    else if (beat_done)  seen <= seen + 1'b1;
  end
  assign want = cur_burst ? CW'(WORDS) : CW'(1);

  assert_arb_before_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_o) |-> $past(bus_req_o));

  assert_frame_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(frame_o) && !$past(retry_hit)) |-> irdy_o);

  assert_irdy_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irdy_o && !trdy_i && !stop_i) |=> irdy_o);

  assert_retry_rearb_R9: assert property (@(posedge clk) disable iff (!rst_n)
    retry_hit |=> (bus_req_o && !frame_o && !irdy_o));

  assert_resp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> (!resp_valid && req_ready));

  assert_all_beats_R10: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (seen == want));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!frame_o && !irdy_o && !bus_req_o));
endmodule

bind cwb_initiator cwb_initiator_chk #(.WORDS(WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_o(frame_o), .irdy_o(irdy_o),
  .bus_req_o(bus_req_o), .trdy_i(trdy_i), .stop_i(stop_i),
  .resp_valid(resp_valid), .req_ready(req_ready), .beat_done(beat_done),
  .retry_hit(retry_hit), .addr_phase(addr_phase), .cur_burst(cur_burst)
);

// File: tb/cwb_initiator_bench.sv
module cwb_initiator_bench;
  logic clk = 0;
  logic rst_n = 0;
  always #10 clk = ~clk;

  logic [31:0]  cfg_win_base = 32'h8000_0000, cfg_win_mask = 32'hF000_0000;
  logic         req_valid = 0, req_ready;
  logic [1:0]   req_op = 0;
  logic [31:0]  req_addr = 0, req_wdata = 0;
  logic [255:0] req_line = 0;
  logic         resp_valid;
  logic [31:0]  resp_data;
  logic [255:0] resp_line;
  logic         bus_req_o, bus_gnt_i = 0, frame_o, irdy_o, ad_oe_o;
  logic [31:0]  ad_o, ad_i = 0;
  logic [3:0]   cmd_o;
  logic         trdy_i = 0, stop_i = 0;

  cwb_initiator u_cwb_initiator (
    .clk(clk), .rst_n(rst_n), .cfg_win_base(cfg_win_base), .cfg_win_mask(cfg_win_mask),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_line(req_line), .resp_valid(resp_valid),
    .resp_data(resp_data), .resp_line(resp_line), .bus_req_o(bus_req_o),
    .bus_gnt_i(bus_gnt_i), .frame_o(frame_o), .irdy_o(irdy_o), .ad_o(ad_o),
    .ad_oe_o(ad_oe_o), .cmd_o(cmd_o), .ad_i(ad_i), .trdy_i(trdy_i), .stop_i(stop_i)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h1357_9BDF;
  endfunction

  typedef struct {
    logic [31:0] addr; logic [3:0] cmd; int beats; int aph; int lat;
    bit rd; bit burst; logic [31:0] data; logic [31:0] line7; logic [31:0] wsum;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  // target model and monitor
  bit retry_pend = 0, wait_mode = 0;
  bit in_tx = 0, tgt_read = 0;
  int cyc = 0, tbeat = 0, fhi = 0, aph = 0, done_cnt = 0;
  logic [31:0] tgt_addr = 0, wsum = 0, p_ad = 0;
  logic [3:0]  tgt_cmd = 0;
  bit p_irdy = 0, p_trdy = 0, p_frame = 0, last_fr = 0, t_trdy, t_stop;

  always @(negedge clk) bus_gnt_i = bus_req_o;

  always @(negedge clk) begin
    if (rst_n) begin
      if (in_tx && p_irdy && p_trdy) begin
        if (!tgt_read) wsum = wsum + p_ad * (tbeat + 1);
        if (p_frame) fhi++;
        last_fr = p_frame;
        tbeat++;
      end
      if (in_tx) cyc++;
      if (resp_valid) begin
        exp_t e;
        if (exp_q.size() == 0) chk(0, "R10", "unexpected response", 0, 0);
        else begin
          e = exp_q.pop_front();
          chk(tgt_addr == e.addr, e.tag, "address", tgt_addr, e.addr);
          chk(tgt_cmd == e.cmd, e.tag, "command", 32'(tgt_cmd), 32'(e.cmd));
          chk(tbeat == e.beats, e.tag, "data phases", tbeat, e.beats);
          chk(fhi == e.beats - 1 && !last_fr, "R7", "frame high count", fhi, e.beats - 1);
          chk(aph == e.aph, "R9", "address phases", aph, e.aph);
          if (e.lat >= 0) chk(cyc == e.lat, "R6", "addr-to-response clocks", cyc, e.lat);
          if (e.rd) begin
            chk(resp_data == e.data, "R10", "resp_data", resp_data, e.data);
            if (e.burst) chk(resp_line[255:224] == e.line7, "R10", "resp_line word7",
                             resp_line[255:224], e.line7);
          end else begin
            chk(wsum == e.wsum, e.tag, "written words", wsum, e.wsum);
          end
        end
        done_cnt++;
      end
      if (frame_o && ad_oe_o && !irdy_o) begin
        aph++; in_tx = 1; cyc = 0; tbeat = 0; wsum = 0; fhi = 0; last_fr = 1;
        tgt_addr = ad_o; tgt_cmd = cmd_o; tgt_read = (cmd_o != 4'h7);
      end else if (in_tx && !frame_o && !irdy_o) begin
        in_tx = 0;
      end
      t_trdy = 0; t_stop = 0;
      if (in_tx && irdy_o && cyc >= (tgt_read ? 2 : 1)) begin
        if (retry_pend && tbeat == 0) begin t_stop = 1; retry_pend = 0; end
        else if (!(wait_mode && cyc[0])) t_trdy = 1;
      end
      trdy_i = t_trdy; stop_i = t_stop;
      ad_i = tgt_read ? mem_word(tgt_addr + 32'(4 * tbeat)) : 32'h0;
      p_irdy = irdy_o; p_trdy = t_trdy; p_frame = frame_o; p_ad = ad_o;
    end
  end

  function automatic logic [255:0] make_line(input logic [31:0] seed);
    logic [255:0] l;
    for (int i = 0; i < 8; i++) l[i*32 +: 32] = seed + 32'(i) * 32'h0101_0111;
    return l;
  endfunction

  task automatic do_req(input logic [1:0] op, input logic [31:0] addr,
                        input logic [31:0] wd, input logic [255:0] line,
                        input bit retry, input bit wm, input string tag);
    exp_t e;
    bit hit;
    hit      = (addr & cfg_win_mask) == cfg_win_base;
    e.burst  = (op == 2'd2) || (op == 2'd0 && hit);
    e.rd     = (op == 2'd0);
    e.addr   = e.burst ? {addr[31:5], 5'b0} : addr;
    e.cmd    = e.rd ? (e.burst ? 4'hE : 4'h6) : 4'h7;
    e.beats  = e.burst ? 8 : 1;
    e.aph    = retry ? 2 : 1;
    e.lat    = (retry || wm) ? -1 : (e.rd ? 2 : 1) + e.beats;
    e.data   = e.burst ? mem_word({addr[31:2], 2'b0}) : mem_word(addr);
    e.line7  = mem_word({addr[31:5], 5'b0} + 32'd28);
    e.wsum   = 0;
    if (e.burst) for (int i = 0; i < 8; i++) e.wsum = e.wsum + line[i*32 +: 32] * (i + 1);
    else e.wsum = wd;
    e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    retry_pend = retry; wait_mode = wm; aph = 0;
    req_op = op; req_addr = addr; req_wdata = wd; req_line = line; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    wait (done_cnt == checks_done_target);
  endtask

  int checks_done_target = 0;

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11: quiet after reset
    chk(req_ready == 1, "R11", "ready after reset", 32'(req_ready), 1);
    chk(!frame_o && !irdy_o && !bus_req_o, "R11", "bus quiet after reset",
        {29'd0, frame_o, irdy_o, bus_req_o}, 0);

    checks_done_target = 1; do_req(2'd0, 32'h8000_1234, 0, 0, 0, 0, "R2");          // window load
    checks_done_target = 2; do_req(2'd0, 32'h4000_0106, 0, 0, 0, 0, "R3");          // miss load
    checks_done_target = 3; do_req(2'd1, 32'h8000_0040, 32'hDEAD_BEEF, 0, 0, 0, "R4"); // store in window
    checks_done_target = 4; do_req(2'd2, 32'h8000_0A64, 0, make_line(32'h1111_0000), 0, 0, "R5");
    checks_done_target = 5; do_req(2'd2, 32'h4000_0A64, 0, make_line(32'h2222_0000), 0, 1, "R5");
    checks_done_target = 6; do_req(2'd0, 32'h8000_07FC, 0, 0, 0, 1, "R8");          // waits
    checks_done_target = 7; do_req(2'd0, 32'h8000_0310, 0, 0, 1, 0, "R9");          // retry burst
    checks_done_target = 8; do_req(2'd2, 32'h8000_0900, 0, make_line(32'h3333_0000), 1, 1, "R9");
    checks_done_target = 9; do_req(2'd0, 32'h0000_0020, 0, 0, 1, 0, "R9");          // retry single
    @(negedge clk);
    cfg_win_base = 32'h2000_0000; cfg_win_mask = 32'hFFF0_0000;
    checks_done_target = 10; do_req(2'd0, 32'h2004_0018, 0, 0, 0, 0, "R1");         // hit
    checks_done_target = 11; do_req(2'd0, 32'h2014_0018, 0, 0, 0, 0, "R1");         // miss
    checks_done_target = 12; do_req(2'd1, 32'h3000_0004, 32'h0BAD_F00D, 0, 1, 1, "R4");
    @(negedge clk);
    chk(req_ready && !bus_req_o && !frame_o, "R11", "idle after traffic",
        {30'd0, req_ready, bus_req_o}, 32'h2);
    chk(exp_q.size() == 0, "R10", "all responses seen", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule